// File: doc/BRIEF.md
# Link Test Pattern Generator and Checker

This block drives a 32-bit parallel transmit word with one of six test patterns and checks a 32-bit receive word against the same pattern. The patterns are four pseudo-random sequences, a highest-frequency alternating pattern and a lowest-frequency pattern that holds its level for 33 bits and then inverts. The block is meant for transceiver loopback testing. The transmit word feeds the serializer path, and the looped-back word returns on the receive port.

Control is a set of single-cycle pulses: start, stop, clear and insert-error. A three-bit code selects the pattern and is captured when a run starts. The checker takes its prediction state from the incoming data, so link latency does not matter. It declares lock after a run of clean words and then runs on its own prediction. Two saturating counters report corrupted words sent and mismatched words received.

Top module: `lpt_pattern_unit`

## Requirements
- R1: Pattern codes 0, 1, 2 and 3 select pseudo-random sequences with the recurrences b[n]=b[n-7]^b[n-6], b[n]=b[n-15]^b[n-14], b[n]=b[n-23]^b[n-18] and b[n]=b[n-31]^b[n-28]. Each sequence starts from a history of all ones. Each word carries the next 32 bits, with the earliest bit in bit 31.
- R2: Code 4 gives the word 32'hAAAAAAAA on every cycle, which is an alternating bit stream that starts with 1. The unused codes 6 and 7 behave exactly like code 4.
- R3: Code 5 gives a stream that starts with 33 ones, then 33 zeros, and repeats. The bit order within a word is the same as in R1.
- R4: The pattern code is captured on the cycle start is accepted. Changes to pat_sel_i during a run have no effect on the transmitted words.
- R5: When start is sampled, the first word appears with tx_valid_o high after the next rising edge. When stop is sampled at an edge, that edge still sends a word, and tx_valid_o is low from the following edge on. Stop takes priority over a simultaneous start, and a run of N cycles sends exactly N words.
- R6: A one-cycle insert-error pulse during a run inverts bit 0 of exactly one transmitted word and raises ins_errs_o by one.
- R7: Insert-error pulses while stopped are ignored. ins_errs_o does not change, and tx_data_o stays 0 with tx_valid_o low.
- R8: sync_o is low after reset and after each accepted start. It rises once 4 consecutive received words match the prediction, and it stays high after stop.
- R9: While synced, each received word that differs from the prediction raises det_errs_o by one. In loopback, det_errs_o equals ins_errs_o after injected errors.
- R10: A single errored word leaves sync high. 4 consecutive errored words drop sync, and each of those words is counted. The checker then locks again on clean data.
- R11: A clear pulse sets both counters to 0 at the next edge. Reset also sets them to 0, and a start leaves them unchanged.
- R12: Both counters saturate at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; captures the pattern code and reseeds the generator and checker |
| stop_i | input | 1 | Stop pulse |
| clear_i | input | 1 | Clears both error counters |
| pat_sel_i | input | 3 | Pattern code |
| inject_i | input | 1 | Insert-error request |
| tx_data_o | output | 32 | Transmit word |
| tx_valid_o | output | 1 | Transmit word valid |
| rx_data_i | input | 32 | Received word |
| rx_valid_i | input | 1 | Received word valid |
| sync_o | output | 1 | Checker locked to the pattern |
| det_errs_o | output | CNT_W | Count of mismatched received words |
| ins_errs_o | output | CNT_W | Count of corrupted transmitted words |

## Verification
A wrong generator history or tap shows on tx_data_o one cycle after it forms, and the scoreboard compares every transmitted word against a bit-serial model. A wrong checker prediction shows as sync_o failing to rise within eight words of a start, or as det_errs_o moving on clean loopback data. Lost-lock and relock faults show within a handful of words after 4 forced bad words. Counter faults show at the edge after an injection, a clear or the saturation point.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int WORD_W = 32;
    localparam int HIST_W = 2 * WORD_W;
    localparam int LF_RUN = 33;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HIST_W-1:0] hist_t;

    typedef enum logic [2:0] {
        PAT_P7  = 3'd0,
        PAT_P15 = 3'd1,
        PAT_P23 = 3'd2,
        PAT_P31 = 3'd3,
        PAT_HF  = 3'd4,
        PAT_LF  = 3'd5
    } pat_e;

    typedef struct packed {
        logic run;
        pat_e pat;
    } run_ctl_t;

    // Unused codes fall back to the alternating pattern.
    function automatic pat_e decode_sel(input logic [2:0] code);
        if (code > 3'd5) return PAT_HF;
        return pat_e'(code);
    endfunction

    // Generator history at start: all ones for the PRBS kinds, zero otherwise.
    function automatic hist_t seed_of(input pat_e p);
        case (p)
            PAT_P7, PAT_P15, PAT_P23, PAT_P31: return '1;
            default:                           return '0;
        endcase
    endfunction

    // h[k] holds the bit k+1 positions before the one being formed.
    function automatic logic tap_bit(input hist_t h, input pat_e p);
        case (p)
            PAT_P7:  return h[6]  ^ h[5];
            PAT_P15: return h[14] ^ h[13];
            PAT_P23: return h[22] ^ h[17];
            PAT_P31: return h[30] ^ h[27];
            PAT_LF:  return ~h[LF_RUN-1];
            default: return ~h[0];
        endcase
    endfunction

    // Forms the next word; the first bit formed lands in the MSB.
    function automatic word_t next_word(input hist_t h_in, input pat_e p);
        hist_t h;
        h = h_in;
        for (int i = 0; i < WORD_W; i++) begin
            h = {h[HIST_W-2:0], tap_bit(h, p)};
        end
        return h[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/lpt_sat_cnt.sv
module lpt_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/lpt_gen.sv
module lpt_gen
    import lpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  pat_e             load_pat_i,
    input  logic             run_i,
    input  pat_e             pat_i,
    input  logic             inject_i,
    input  logic             clear_i,
    output word_t            tx_data_o,
    output logic             tx_valid_o,
    output logic [CNT_W-1:0] ins_cnt_o
);
    hist_t hist_q;
    word_t data_q;
    logic  valid_q;
    word_t clean_w;
    word_t flip_w;
    logic  bump;

    assign clean_w = next_word(hist_q, pat_i);
    assign bump    = run_i & inject_i & ~load_i;
    assign flip_w  = {{(WORD_W-1){1'b0}}, bump};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q  <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (load_i) begin
            hist_q  <= seed_of(load_pat_i);
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (run_i) begin
            // The history keeps the clean word; only the output is corrupted.
            hist_q  <= {hist_q[WORD_W-1:0], clean_w};
            data_q  <= clean_w ^ flip_w;
            valid_q <= 1'b1;
        end else begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end
    end

    lpt_sat_cnt #(.W(CNT_W)) u_ins_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clear_i),
        .inc_i (bump),
        .cnt_o (ins_cnt_o)
    );

    assign tx_data_o  = data_q;
    assign tx_valid_o = valid_q;
endmodule

// File: rtl/lpt_chk.sv
module lpt_chk
    import lpt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SYNC_RUN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  pat_e             pat_i,
    input  logic             rx_valid_i,
    input  word_t            rx_data_i,
    input  logic             clear_i,
    output logic             sync_o,
    output logic [CNT_W-1:0] det_cnt_o
);
    localparam int ST_W = (SYNC_RUN > 1) ? $clog2(SYNC_RUN) : 1;
    localparam logic [ST_W-1:0] ST_LAST = ST_W'(SYNC_RUN - 1);

    hist_t          ref_q;
    logic           synced_q;
    logic [ST_W-1:0] streak_q;
    word_t          exp_w;
    logic           miss;
    logic           count_it;

    assign exp_w    = next_word(ref_q, pat_i);
    assign miss     = (rx_data_i != exp_w);
    assign count_it = rx_valid_i & synced_q & miss & ~restart_i;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            ref_q    <= '0;
            synced_q <= 1'b0;
            streak_q <= '0;
        end else if (rx_valid_i) begin
            // Before lock the history follows the line; after lock it runs free.
            ref_q <= {ref_q[WORD_W-1:0], synced_q ? exp_w : rx_data_i};
            if (!synced_q) begin
                if (miss) begin
                    streak_q <= '0;
                end else if (streak_q == ST_LAST) begin
                    synced_q <= 1'b1;
                    streak_q <= '0;
                end else begin
                    streak_q <= streak_q + 1'b1;
                end
            end else begin
                if (!miss) begin
                    streak_q <= '0;
                end else if (streak_q == ST_LAST) begin
                    synced_q <= 1'b0;
                    streak_q <= '0;
                end else begin
                    streak_q <= streak_q + 1'b1;
                end
            end
        end
    end

    lpt_sat_cnt #(.W(CNT_W)) u_det_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clear_i),
        .inc_i (count_it),
        .cnt_o (det_cnt_o)
    );

    assign sync_o = synced_q;
endmodule

// File: rtl/lpt_pattern_unit.sv
module lpt_pattern_unit
    import lpt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SYNC_RUN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             clear_i,
    input  logic [2:0]       pat_sel_i,
    input  logic             inject_i,
    output logic [31:0]      tx_data_o,
    output logic             tx_valid_o,
    input  logic [31:0]      rx_data_i,
    input  logic             rx_valid_i,
    output logic             sync_o,
    output logic [CNT_W-1:0] det_errs_o,
    output logic [CNT_W-1:0] ins_errs_o
);
    run_ctl_t ctl_q;
    logic     run_q;
    logic     restart;
    pat_e     new_pat;

    assign restart = start_i & ~stop_i;
    assign new_pat = decode_sel(pat_sel_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{run: 1'b0, pat: PAT_P7};
        end else if (stop_i) begin
            ctl_q.run <= 1'b0;
        end else if (start_i) begin
            ctl_q <= '{run: 1'b1, pat: new_pat};
        end
    end

    assign run_q = ctl_q.run;

    lpt_gen #(.CNT_W(CNT_W)) u_gen (
        .clk        (clk),
        .rst        (rst),
        .load_i     (restart),
        .load_pat_i (new_pat),
        .run_i      (run_q),
        .pat_i      (ctl_q.pat),
        .inject_i   (inject_i),
        .clear_i    (clear_i),
        .tx_data_o  (tx_data_o),
        .tx_valid_o (tx_valid_o),
        .ins_cnt_o  (ins_errs_o)
    );

    lpt_chk #(.CNT_W(CNT_W), .SYNC_RUN(SYNC_RUN)) u_chk (
        .clk        (clk),
        .rst        (rst),
        .restart_i  (restart),
        .pat_i      (ctl_q.pat),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .clear_i    (clear_i),
        .sync_o     (sync_o),
        .det_cnt_o  (det_errs_o)
    );
endmodule

// File: rtl/lpt_pattern_unit_sva.sv
module lpt_pattern_unit_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             stop_i,
    input logic             clear_i,
    input logic             run_q,
    input logic             tx_valid_o,
    input logic             sync_o,
    input logic [CNT_W-1:0] det_errs_o,
    input logic [CNT_W-1:0] ins_errs_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    a_r5_stop_ends_valid: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> ##1 !tx_valid_o);

    a_r6_ins_single_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(clear_i) && ins_errs_o != $past(ins_errs_o))
            |-> ins_errs_o == $past(ins_errs_o) + 1'b1);

    a_r7_idle_no_insert: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !clear_i) |=> ins_errs_o == $past(ins_errs_o));

    a_r8_start_unlocks: assert property (@(posedge clk) disable iff (rst)
        (start_i && !stop_i) |=> !sync_o);

    a_r10_count_needs_sync: assert property (@(posedge clk) disable iff (rst)
        (!$past(clear_i) && det_errs_o != $past(det_errs_o)) |-> $past(sync_o));

    a_r11_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (det_errs_o == '0 && ins_errs_o == '0));

    a_r12_ins_holds_top: assert property (@(posedge clk) disable iff (rst)
        ($past(ins_errs_o) == TOP && !$past(clear_i)) |-> ins_errs_o == TOP);

    a_r12_det_holds_top: assert property (@(posedge clk) disable iff (rst)
        ($past(det_errs_o) == TOP && !$past(clear_i)) |-> det_errs_o == TOP);
endmodule

bind lpt_pattern_unit lpt_pattern_unit_sva #(.CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .clear_i    (clear_i),
    .run_q      (run_q),
    .tx_valid_o (tx_valid_o),
    .sync_o     (sync_o),
    .det_errs_o (det_errs_o),
    .ins_errs_o (ins_errs_o)
);

// File: tb/lpt_pattern_unit_test.sv
module lpt_pattern_unit_test;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0, stop = 1'b0, clear = 1'b0, inject = 1'b0;
    logic [2:0]    psel = 3'd0;
    logic [31:0]   flip = 32'h0;
    logic [31:0]   txd, rxd;
    logic          txv, sync;
    logic [CW-1:0] det, ins;

    assign rxd = txd ^ flip;

    lpt_pattern_unit #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .start_i(start), .stop_i(stop), .clear_i(clear),
        .pat_sel_i(psel), .inject_i(inject), .tx_data_o(txd), .tx_valid_o(txv),
        .rx_data_i(rxd), .rx_valid_i(txv), .sync_o(sync),
        .det_errs_o(det), .ins_errs_o(ins)
    );

    always #2 clk = ~clk;

    int          checks = 0, errors = 0;
    bit          done = 0;
    string       cur_req = "R1";
    logic [31:0] exp_q[$];
    logic [31:0] mon_e;
    bit          inj_at[0:1023];
    bit          flip_at[0:1023];
    int          chg_at = 0;
    bit          loss_mode = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard on every valid transmit word.
    always @(negedge clk) begin
        if (!rst && txv) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 word beyond run length", {32'h0, txd}, 64'h0);
            end else begin
                mon_e = exp_q.pop_front();
                chk(txd == mon_e, cur_req, {32'h0, txd}, {32'h0, mon_e});
            end
        end
    end

    // Driver side of the scoreboard: bit-serial model of each pattern.
    task automatic load_expect(input logic [2:0] code, input int n);
        int eff, nn, mm, gb;
        bit bq[$];
        logic [31:0] word;
        bit nb;
        eff = (code > 3'd5) ? 4 : int'(code);
        nn = 0; mm = 0; gb = 0;
        case (eff)
            0: begin nn = 7;  mm = 6;  end
            1: begin nn = 15; mm = 14; end
            2: begin nn = 23; mm = 18; end
            3: begin nn = 31; mm = 28; end
            default: ;
        endcase
        if (eff < 4) repeat (nn) bq.push_back(1'b1);
        for (int w = 1; w <= n; w++) begin
            for (int b = 0; b < 32; b++) begin
                if (eff < 4) begin
                    nb = bq[bq.size()-nn] ^ bq[bq.size()-mm];
                    bq.push_back(nb);
                end else if (eff == 4) begin
                    nb = (gb % 2 == 0);
                end else begin
                    nb = ((gb / 33) % 2 == 0);
                end
                gb++;
                word[31-b] = nb;
            end
            if (inj_at[w]) word[0] = ~word[0];
            exp_q.push_back(word);
        end
    endtask

    task automatic run_test(input logic [2:0] code, input int n, input string req);
        cur_req = req;
        load_expect(code, n);
        @(negedge clk);
        psel  = code;
        start = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (i == 1) start = 1'b0;
            inject = inj_at[i];
            flip   = flip_at[i] ? 32'h1 : 32'h0;
            if (i == chg_at) psel = (code == 3'd5) ? 3'd0 : 3'd5;
            if (i == 5)  chk(sync == 1'b0, "R8 not locked after 3 words", {63'h0, sync}, 64'h0);
            if (i == 8)  chk(sync == 1'b1, "R8 locked after clean words", {63'h0, sync}, 64'h1);
            if (loss_mode && i == 15) chk(sync == 1'b1, "R10 lock kept after one bad word", {63'h0, sync}, 64'h1);
            if (loss_mode && i == 24) chk(sync == 1'b0, "R10 lock lost after 4 bad words", {63'h0, sync}, 64'h0);
            if (i == n) stop = 1'b1;
        end
        @(negedge clk);
        stop = 1'b0; inject = 1'b0; flip = 32'h0;
        @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R5 run length in words", exp_q.size(), 0);
        chk(txv == 1'b0, "R5 valid low after stop", {63'h0, txv}, 64'h0);
        for (int k = 0; k < 1024; k++) begin
            inj_at[k]  = 1'b0;
            flip_at[k] = 1'b0;
        end
        chg_at = 0;
        loss_mode = 0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] ins_before;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txv == 1'b0, "R5 idle after reset", {63'h0, txv}, 64'h0);
        chk(sync == 1'b0, "R8 unlocked after reset", {63'h0, sync}, 64'h0);
        chk(det == 0 && ins == 0, "R11 counters zero after reset", {det, ins}, 64'h0);

        // R7: insert-error while stopped
        ins_before = ins;
        @(negedge clk); inject = 1'b1;
        @(negedge clk); inject = 1'b0;
        chk(ins == ins_before, "R7 idle inject not counted", ins, ins_before);
        chk(txv == 1'b0 && txd == 32'h0, "R7 idle transmit untouched", {txv, txd}, 64'h0);

        // R5: stop beats a simultaneous start
        @(negedge clk); start = 1'b1; stop = 1'b1;
        @(negedge clk); start = 1'b0; stop = 1'b0;
        @(negedge clk);
        chk(txv == 1'b0, "R5 stop wins over start", {63'h0, txv}, 64'h0);

        run_test(3'd0, 40, "R1 PRBS7 word");
        run_test(3'd1, 40, "R1 PRBS15 word");
        run_test(3'd2, 40, "R1 PRBS23 word");
        run_test(3'd3, 40, "R1 PRBS31 word");
        run_test(3'd4, 40, "R2 alternating word");
        run_test(3'd7, 40, "R2 reserved code word");
        run_test(3'd5, 70, "R3 long-run word");
        chk(sync == 1'b1, "R8 lock held after stop", {63'h0, sync}, 64'h1);
        chk(det == 0, "R9 no errors on clean loopback", det, 0);

        chg_at = 3;
        run_test(3'd0, 30, "R4 select change ignored");

        inj_at[6] = 1'b1; inj_at[12] = 1'b1;
        run_test(3'd3, 20, "R6 injected word");
        chk(ins == 2, "R6 inserted count", ins, 2);
        chk(det == 2, "R9 detected equals inserted", det, 2);

        run_test(3'd4, 12, "R2 alternating word");
        chk(ins == 2 && det == 2, "R11 start keeps counters", {det, ins}, {8'd2, 8'd2});

        pulse_clear();
        @(negedge clk);
        chk(ins == 0 && det == 0, "R11 clear zeroes counters", {det, ins}, 64'h0);

        loss_mode = 1;
        flip_at[10] = 1'b1;
        for (int k = 20; k <= 23; k++) flip_at[k] = 1'b1;
        run_test(3'd4, 40, "R2 alternating word");
        chk(det == 5, "R10 bad words counted", det, 5);
        chk(sync == 1'b1, "R10 relock on clean data", {63'h0, sync}, 64'h1);
        chk(ins == 0, "R10 receive faults not inserted", ins, 0);

        pulse_clear();
        for (int k = 12; k <= 600; k += 2) inj_at[k] = 1'b1;
        run_test(3'd1, 600, "R12 PRBS15 word");
        chk(ins == 8'hFF, "R12 inserted saturates", ins, 8'hFF);
        chk(det == 8'hFF, "R12 detected saturates", det, 8'hFF);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule